// File: doc/BRIEF.md
# Integer-Factor Upsampler with Zero-Fill or Hold

This block raises the sample rate of a signed data stream by a fixed integer factor N. A free-running phase counter splits time into frames of N clock cycles. One input sample is accepted in the last cycle of each frame. During the next frame the block drives one output word on every clock cycle.

A mode input selects how the gap after each sample is filled. In zero-fill mode the sample appears for one cycle and is followed by N-1 zero words, which is classic zero-stuffing ahead of an interpolation filter. In hold mode the sample is repeated on all N cycles, which gives a sample-and-hold stream. The mode is sampled once per frame, together with the sample. The source must present data at 1/N of the clock rate, and its valid strobe must line up with the accept cycle. A strobe at any other cycle is dropped and sets a sticky error flag.

Top module: `upsample_fill`

## Requirements
- R1: While reset is high, and in the cycle after it, `outData` is 0, `outValid` is 0 and `errFlag` is 0. The phase counter restarts at 0 in the first cycle after reset.
- R2: The accept cycle is the last cycle of each N-cycle frame. The first accept cycle is the Nth cycle after reset is released, and accept cycles then repeat every N cycles.
- R3: With `modeHold`=0 latched for the frame, the accepted sample is output for one cycle and is followed by N-1 cycles of zero.
- R4: With `modeHold`=1 latched for the frame, the accepted sample is output on all N cycles of the frame.
- R5: A sample accepted in an accept cycle appears on `outData` in the next cycle, which is the first cycle of the new frame.
- R6: `outValid` stays 0 until the first sample is accepted. From the following cycle it stays 1 on every cycle until reset.
- R7: `modeHold` is sampled only in the accept cycle. A change in any other cycle has no effect on the frame currently being output.
- R8: If `inValid` is 0 in an accept cycle, the following frame outputs zero on all N cycles in either mode, and `outValid` stays as it was.
- R9: An `inValid` pulse outside an accept cycle does not change `outData`. It sets `errFlag`, which stays 1 until reset.
- R10: With N=1, every cycle is an accept cycle. A valid input appears on `outData` one cycle later in both modes, and a cycle with no valid input gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeHold | input | 1 | 1 = repeat the sample for the whole frame, 0 = insert zeros |
| inValid | input | 1 | Input sample strobe, expected only in accept cycles |
| inData | input | WIDTH | Signed input sample |
| outData | output | WIDTH | Signed output word, one per cycle |
| outValid | output | 1 | High on every cycle once the first sample has been accepted |
| errFlag | output | 1 | Sticky flag for an input strobe outside an accept cycle |

## Verification
A phase counter that has drifted moves the accept cycle. The bench then sees, within one frame, a sample landing late or missing, a spurious `errFlag`, or a frame that is too short. A mode latch that follows the live input shows up in the next non-load cycle, because the bench flips `modeHold` mid-frame: a zero-fill frame turns into a repeat, or the reverse. A fill path that loses its state gives a wrong word on the second cycle of a frame.

// File: rtl/ups_pkg.sv
package ups_pkg;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic loadEn;      // accept cycle: last phase of the frame
    logic takeSample;  // accept cycle with a valid input
    logic holdSel;     // fill mode latched for the current frame
  } ups_strobe_t;

endpackage

// File: rtl/ups_ctrl.sv
module ups_ctrl
  import ups_pkg::*;
#(
  parameter int FACTOR = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        modeHold,
  input  logic        inValid,
  output ups_strobe_t strobes,
  output logic        errFlag
);

  localparam int PW = (FACTOR > 1) ? $clog2(FACTOR) : 1;
  localparam logic [PW-1:0] LAST = PW'(FACTOR - 1);

  logic [PW-1:0] phase;
  logic          loadEn;
  logic          holdSel;

  assign loadEn = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= loadEn ? '0 : phase + 1'b1;
  end

  // mode is captured together with the sample, once per frame
  always_ff @(posedge clk) begin
    if (rst)         holdSel <= 1'b0;
    else if (loadEn) holdSel <= modeHold;
  end

  always_ff @(posedge clk) begin
    if (rst)                      errFlag <= 1'b0;
    else if (inValid && !loadEn)  errFlag <= 1'b1;
  end

  assign strobes = '{loadEn: loadEn, takeSample: loadEn & inValid, holdSel: holdSel};

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst) phase <= LAST);
  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst) loadEn |=> (phase == '0));
  // R7
  mode_latch_chk: assert property (@(posedge clk) disable iff (rst) !loadEn |=> $stable(holdSel));
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (rst) (inValid && !loadEn) |=> errFlag);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) errFlag |=> errFlag);

endmodule

// File: rtl/ups_datapath.sv
module ups_datapath
  import ups_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ups_strobe_t             strobes,
  input  logic signed [WIDTH-1:0] inData,
  output logic signed [WIDTH-1:0] outData,
  output logic                    outValid
);

  // The output register doubles as the hold store for the frame
  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobes.loadEn)
        outData <= strobes.takeSample ? inData : '0;
      else if (!strobes.holdSel)
        outData <= '0;
      if (strobes.takeSample)
        outValid <= 1'b1;
    end
  end

  // R5
  load_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.takeSample |=> (outData == $past(inData)));
  // R3
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadEn && !strobes.holdSel) |=> (outData == '0));
  // R4
  hold_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadEn && strobes.holdSel) |=> $stable(outData));
  // R8
  missing_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadEn && !strobes.takeSample) |=> (outData == '0));
  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> outValid);

endmodule

// File: rtl/upsample_fill.sv
module upsample_fill
  import ups_pkg::*;
#(
  parameter int FACTOR = 4,
  parameter int WIDTH  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    modeHold,
  input  logic                    inValid,
  input  logic signed [WIDTH-1:0] inData,
  output logic signed [WIDTH-1:0] outData,
  output logic                    outValid,
  output logic                    errFlag
);

  ups_strobe_t strobes;

  ups_ctrl #(.FACTOR(FACTOR)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .modeHold (modeHold),
    .inValid  (inValid),
    .strobes  (strobes),
    .errFlag  (errFlag)
  );

  ups_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inData   (inData),
    .outData  (outData),
    .outValid (outValid)
  );

endmodule

// File: tb/sim_upsample_fill.sv
module sim_upsample_fill;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 8;

  typedef struct packed {
    logic       mode;
    logic       valid;
    logic [7:0] data;
    logic [7:0] expFirst;
    logic [7:0] expFill;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'h25, 8'h25, 8'h25},  // R4 hold
    '{1'b0, 1'b1, 8'hFD, 8'hFD, 8'h00},  // R3 zero-fill, negative
    '{1'b1, 1'b1, 8'h80, 8'h80, 8'h80},  // R4 most negative
    '{1'b0, 1'b0, 8'h11, 8'h00, 8'h00},  // R8 missing, zero mode
    '{1'b1, 1'b0, 8'h22, 8'h00, 8'h00},  // R8 missing, hold mode
    '{1'b0, 1'b1, 8'h7F, 8'h7F, 8'h00},  // R3 most positive
    '{1'b1, 1'b1, 8'h01, 8'h01, 8'h01},  // R4
    '{1'b1, 1'b1, 8'h00, 8'h00, 8'h00}   // R4 zero sample
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeHold = 1'b0, inValid = 1'b0;
  logic signed [W-1:0] inData = '0;
  logic signed [W-1:0] outData;
  logic outValid, errFlag;

  logic mode1 = 1'b0, inValid1 = 1'b0;
  logic signed [W-1:0] inData1 = '0;
  logic signed [W-1:0] outData1;
  logic outValid1, errFlag1;

  int nVec = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upsample_fill #(.FACTOR(N), .WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .modeHold(modeHold), .inValid(inValid), .inData(inData),
    .outData(outData), .outValid(outValid), .errFlag(errFlag));

  upsample_fill #(.FACTOR(1), .WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .modeHold(mode1), .inValid(inValid1), .inData(inData1),
    .outData(outData1), .outValid(outValid1), .errFlag(errFlag1));

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outData in reset", int'(outData), 0);
    chk("R1 outValid in reset", int'(outValid), 0);
    chk("R1 errFlag in reset", int'(errFlag), 0);
    rst = 1'b0;

    // table walk: slot k of frame e-1 is visible in phase k of frame e
    for (int e = 0; e < NV; e++) begin
      for (int k = 0; k < N; k++) begin
        if (!(e == 0 && k == 0)) @(negedge clk);
        if (e == 0) begin
          chk("R6 outValid before first sample", int'(outValid), 0);
          chk("R1 outData before first sample", int'(outData), 0);
        end else begin
          chk("R3/R4/R5/R7/R8 outData slot",
              int'(outData) & 8'hFF,
              int'((k == 0) ? VECS[e-1].expFirst : VECS[e-1].expFill));
          chk("R6 outValid", int'(outValid), 1);
        end
        if (k == N - 1) begin
          inValid  = VECS[e].valid;
          inData   = VECS[e].data;
          modeHold = VECS[e].mode;
        end else begin
          inValid  = 1'b0;
          inData   = 8'hAA;
          modeHold = ~VECS[e].mode;  // R7 mid-frame toggle
        end
      end
    end

    // flush the last frame; the final accept cycle carries no sample
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      chk("R4 last frame slot", int'(outData) & 8'hFF,
          int'((k == 0) ? VECS[NV-1].expFirst : VECS[NV-1].expFill));
      inValid = 1'b0; inData = 8'h5A; modeHold = 1'b0;
    end
    chk("R9 errFlag clear after aligned input", int'(errFlag), 0);

    // R2 stray strobe in phase 0 of a missing-sample zero frame
    @(negedge clk);
    chk("R8 missing sample slot 0", int'(outData), 0);
    chk("R8 outValid kept", int'(outValid), 1);
    inValid = 1'b1; inData = 8'h55;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 stray strobe ignored", int'(outData), 0);
    chk("R9 errFlag set", int'(errFlag), 1);
    repeat (N) @(negedge clk);
    chk("R9 errFlag sticky", int'(errFlag), 1);

    // R1 reset again
    rst = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 errFlag after reset", int'(errFlag), 0);
    chk("R1 outData after reset", int'(outData), 0);
    rst = 1'b0;
    // R2 first accept is the Nth cycle after release
    for (int k = 0; k < N; k++) begin
      inValid = (k == N - 1); inData = 8'h3C; modeHold = 1'b0;
      @(negedge clk);
    end
    inValid = 1'b0;
    chk("R2 first accept timing outData", int'(outData), 8'h3C);
    chk("R2 no error on aligned accept", int'(errFlag), 0);
    @(negedge clk);
    chk("R3 zero after sample", int'(outData), 0);

    // R10 N=1 pass-through, mode toggling, some cycles empty
    for (int i = 0; i < 12; i++) begin
      inValid1 = (i % 3 != 2);
      inData1  = W'(i * 37 - 100);
      mode1    = i[0];
      @(negedge clk);
      chk("R10 N=1 outData", int'(outData1),
          (i % 3 != 2) ? int'(W'(i * 37 - 100)) : 0);
      chk("R10 N=1 outValid", int'(outValid1), 1);
    end
    chk("R10 N=1 no error", int'(errFlag1), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule